// File: doc/BRIEF.md
# Capture/Compare Timer Unit

This block is a 16-bit up-counter with four capture channels and three compare channels that drive eight timed output pins. The counter advances on a divided internal clock or on rising edges of an external event pin. A rising edge on a clear pin sends it back to zero. Each capture channel copies the counter into its own register when its pin shows the edge kind that was programmed for it. The three compare registers each have a fixed job. A match on the first drives six outputs high through a mask. A match on the second drives them low through a second mask. A match on the third inverts two further outputs through an enable mask.

Software sets the unit up and reads it back through a flat port that takes single-cycle writes and returns reads combinationally. Each event raises its own sticky flag. The flags are visible on a port, so an interrupt controller outside the block can use them. Software clears a flag by writing a 1 to its bit. Every external pin passes through a two-stage synchronizer before its edges are detected.

Top module: `cct_timer_unit`

## Requirements
- R1: After reset the counter, every capture, compare and mask register, all flags and all eight outputs read zero, and the counter is stopped.
- R2: With CTRL bit 0 (run) set and CTRL bit 1 (external) clear, the counter (address 2) steps by one every 2^p clocks, where p is CTRL[3:2]. The first step comes 2^p edges after the edge that wrote run.
- R3: While run is clear the counter holds its value, and pulses on the event pin have no effect.
- R4: With run and external both set, the counter steps once per rising edge of the event pin. A pin change before edge k takes effect at edge k+2. The prescaler is not used in this mode.
- R5: A rising edge on the clear pin zeroes the counter at edge k+2 and has priority over a step. Holding the pin high does not clear the counter again.
- R6: Capture channel i is programmed by CTRL[9+2i:8+2i]: 01 selects rising edges, 10 falling edges and 11 both. On a selected edge seen before edge k, capture register i (address 3+i) takes, at edge k+2, the count held just before that edge, and flag bit 1+i is set.
- R7: A capture channel programmed 00 never changes its register or its flag, whatever its pin does.
- R8: Compare registers sit at addresses 7, 8 and 9. When the counter takes a new value equal to compare 0, the six set/reset outputs named by the set mask (address 10) go high at that same edge. On a match with compare 1, the outputs named by the reset mask (address 11) go low. No other event changes these outputs.
- R9: When compare 0 and compare 1 match at the same edge, an output named in both masks ends high.
- R10: On a match with compare 2, each toggle output whose bit is set in the toggle-enable register (address 12) inverts. At all other times the toggle outputs hold.
- R11: A step from 0xFFFF to 0x0000 sets flag bit 0. Flag bits 7:5 record matches on compares 0 to 2. The flags are readable at address 1 and appear on the flag port.
- R12: Writing to address 1 clears each flag whose bit is 1 in the written data and leaves the other flags as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_pin | input | 4 | Capture trigger pins, asynchronous |
| evt_pin | input | 1 | External count event pin, asynchronous |
| clr_pin | input | 1 | Counter clear pin, acts on its rising edge |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| sr_out | output | 6 | Outputs set/reset by compares 0 and 1 |
| tg_out | output | 2 | Outputs toggled by compare 2 |
| evt_flags | output | 8 | Sticky event flags: overflow, four captures, three compares |

## Verification
Random rounds pick a prescale setting, three compare values just ahead of the counter, and random set, reset and toggle masks. The bench then checks the counter and all eight outputs on every cycle against a cycle model. These rounds separate wrong divide ratios, off-by-one match timing, masks that are applied wrongly, and the wrong winner when a set and a reset collide (one round forces the two compares to be equal). Directed cases use pin edges while the counter is running to fix the two-clock synchronizer latency of the capture, clear and event paths. They also cover rising, falling, both and off edge selections across the four channels, a full wrap to catch the overflow flag on the exact edge, and selective write-1-to-clear of the flags.

// File: rtl/cct_pkg.sv
package cct_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // edge-select codes for one capture channel; bit 0 = rising, bit 1 = falling
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    // register addresses
    localparam logic [3:0] A_CTRL  = 4'd0;
    localparam logic [3:0] A_FLAGS = 4'd1;
    localparam logic [3:0] A_COUNT = 4'd2;
    localparam logic [3:0] A_CAP0  = 4'd3;
    localparam logic [3:0] A_CMP0  = 4'd7;
    localparam logic [3:0] A_SMASK = 4'd10;
    localparam logic [3:0] A_RMASK = 4'd11;
    localparam logic [3:0] A_TGEN  = 4'd12;

    // CTRL layout
    localparam int CTRL_RUN  = 0;
    localparam int CTRL_EXT  = 1;
    localparam int CTRL_PSEL = 2;
    localparam int CTRL_ESEL = 8;
endpackage

// File: rtl/cct_sync.sv
module cct_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur  = st_q.s2;
    assign prev = st_q.s3;
endmodule

// File: rtl/cct_timebase.sv
module cct_timebase #(
    parameter int TW  = 16,
    parameter int PSW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           ext_sel,
    input  logic [PSW-1:0] psel,
    input  logic           evt_rise,
    input  logic           clr_rise,
    output logic [TW-1:0]  cnt,
    output logic [TW-1:0]  cnt_next,
    output logic           upd,
    output logic           wrap
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int PRE_W = (1 << PSW) - 1;

    typedef struct packed {
        logic [TW-1:0]    cnt;
        logic [PRE_W-1:0] pre;
    } tb_t;

    tb_t              st_d, st_q;
    logic [PRE_W-1:0] pre_lim;
    logic             tick;

    always_comb begin
        st_d    = st_q;
        tick    = 1'b0;
        pre_lim = PRE_W'((32'd1 << psel) - 32'd1);
        if (run) begin
            if (ext_sel) begin
                tick = evt_rise;
            end else if (st_q.pre >= pre_lim) begin
                tick     = 1'b1;
                st_d.pre = '0;
            end else begin
                st_d.pre = st_q.pre + 1'b1;
            end
        end else begin
            st_d.pre = '0;
        end
        if (clr_rise) begin
            st_d.cnt = '0;
            st_d.pre = '0;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt      = st_q.cnt;
    assign cnt_next = st_d.cnt;
    assign upd      = tick | clr_rise;
    assign wrap     = tick & ~clr_rise & (&st_q.cnt);

    // R5
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_rise |=> (cnt == '0));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_rise && !tick) |=> $stable(cnt));

    // R2
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr_rise) |=> (cnt == TW'($past(cnt) + 1'b1)));
endmodule

// File: rtl/cct_capture.sv
module cct_capture #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    esel,
    input  logic          rise,
    input  logic          fall,
    input  logic [TW-1:0] cnt,
    output logic          fire,
    output logic [TW-1:0] val
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        logic [TW-1:0] val;
    } cap_t;

    cap_t st_d, st_q;

    always_comb begin
        fire = (rise & esel[0]) | (fall & esel[1]);
        st_d = st_q;
        if (fire) st_d.val = cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val = st_q.val;

    // R6
    cap_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (val == $past(cnt)));

    // R7
    cap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(val));
endmodule

// File: rtl/cct_cmp_out.sv
module cct_cmp_out #(
    parameter int TW  = 16,
    parameter int NSR = 6,
    parameter int NTG = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           upd,
    input  logic [TW-1:0]  cnt_next,
    input  logic [TW-1:0]  cmp_set,
    input  logic [TW-1:0]  cmp_rst,
    input  logic [TW-1:0]  cmp_tgl,
    input  logic [NSR-1:0] smask,
    input  logic [NSR-1:0] rmask,
    input  logic [NTG-1:0] tgen,
    output logic [NSR-1:0] sr_out,
    output logic [NTG-1:0] tg_out,
    output logic [2:0]     hit
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        logic [NSR-1:0] sr;
        logic [NTG-1:0] tg;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        hit[0] = upd && (cnt_next == cmp_set);
        hit[1] = upd && (cnt_next == cmp_rst);
        hit[2] = upd && (cnt_next == cmp_tgl);
        st_d   = st_q;
        if (hit[1]) st_d.sr = st_q.sr & ~rmask;
        if (hit[0]) st_d.sr = st_d.sr | smask;
        if (hit[2]) st_d.tg = st_q.tg ^ tgen;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sr_out = st_q.sr;
    assign tg_out = st_q.tg;

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[0] && hit[1]) |=> ((sr_out & $past(smask)) == $past(smask)));

    // R8
    sr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit[0] && !hit[1]) |=> $stable(sr_out));

    // R10
    tg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit[2] |=> $stable(tg_out));
endmodule

// File: rtl/cct_timer_unit.sv
module cct_timer_unit
    import cct_pkg::*;
#(
    parameter int TW   = 16,
    parameter int NCAP = 4,
    parameter int NSR  = 6,
    parameter int NTG  = 2,
    parameter int PSW  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCAP-1:0]       cap_pin,
    input  logic                  evt_pin,
    input  logic                  clr_pin,
    input  logic [3:0]            reg_addr,
    input  logic                  reg_wr,
    input  logic [TW-1:0]         reg_wdata,
    output logic [TW-1:0]         reg_rdata,
    output logic [NSR-1:0]        sr_out,
    output logic [NTG-1:0]        tg_out,
    output logic [NCAP+3:0]       evt_flags
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NCMP  = 3;
    localparam int NFLAG = 1 + NCAP + NCMP;
    localparam int NPIN  = NCAP + 2;

    typedef struct packed {
        logic                     run;
        logic                     ext;
        logic [PSW-1:0]           psel;
        logic [NCAP-1:0][1:0]     esel;
        logic [NCMP-1:0][TW-1:0]  cmp;
        logic [NSR-1:0]           smask;
        logic [NSR-1:0]           rmask;
        logic [NTG-1:0]           tgen;
        logic [NFLAG-1:0]         flags;
    } cfg_t;

    cfg_t st_d, st_q;

    // pin synchronizers and edge detection
    logic [NPIN-1:0] pin_cur, pin_prev;
    logic [NCAP-1:0] cap_rise, cap_fall;
    logic            evt_rise, clr_rise;

    cct_sync #(.W(NPIN)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({clr_pin, evt_pin, cap_pin}),
        .cur  (pin_cur),
        .prev (pin_prev)
    );

    assign cap_rise = pin_cur[NCAP-1:0] & ~pin_prev[NCAP-1:0];
    assign cap_fall = ~pin_cur[NCAP-1:0] & pin_prev[NCAP-1:0];
    assign evt_rise = pin_cur[NCAP] & ~pin_prev[NCAP];
    assign clr_rise = pin_cur[NCAP+1] & ~pin_prev[NCAP+1];

    // counter
    logic [TW-1:0] cnt, cnt_next;
    logic          upd, wrap;

    cct_timebase #(.TW(TW), .PSW(PSW)) u_tbase (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q.run),
        .ext_sel (st_q.ext),
        .psel    (st_q.psel),
        .evt_rise(evt_rise),
        .clr_rise(clr_rise),
        .cnt     (cnt),
        .cnt_next(cnt_next),
        .upd     (upd),
        .wrap    (wrap)
    );

    // capture channels
    logic [NCAP-1:0][TW-1:0] cap_val;
    logic [NCAP-1:0]         cap_fire;

    for (genvar g = 0; g < NCAP; g++) begin : g_cap
        cct_capture #(.TW(TW)) u_cap (
            .clk  (clk),
            .rst_n(rst_n),
            .esel (st_q.esel[g]),
            .rise (cap_rise[g]),
            .fall (cap_fall[g]),
            .cnt  (cnt),
            .fire (cap_fire[g]),
            .val  (cap_val[g])
        );
    end

    // compare outputs
    logic [NCMP-1:0] hit;

    cct_cmp_out #(.TW(TW), .NSR(NSR), .NTG(NTG)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (upd),
        .cnt_next(cnt_next),
        .cmp_set (st_q.cmp[0]),
        .cmp_rst (st_q.cmp[1]),
        .cmp_tgl (st_q.cmp[2]),
        .smask   (st_q.smask),
        .rmask   (st_q.rmask),
        .tgen    (st_q.tgen),
        .sr_out  (sr_out),
        .tg_out  (tg_out),
        .hit     (hit)
    );

    // configuration writes and flag update
    logic [NFLAG-1:0] flag_set, flag_clr;

    always_comb begin
        st_d     = st_q;
        flag_set = {hit, cap_fire, wrap};
        flag_clr = '0;
        if (reg_wr) begin
            case (reg_addr)
                A_CTRL: begin
                    st_d.run  = reg_wdata[CTRL_RUN];
                    st_d.ext  = reg_wdata[CTRL_EXT];
                    st_d.psel = reg_wdata[CTRL_PSEL +: PSW];
                    for (int i = 0; i < NCAP; i++) begin
                        st_d.esel[i] = reg_wdata[CTRL_ESEL + 2*i +: 2];
                    end
                end
                A_FLAGS: flag_clr   = reg_wdata[NFLAG-1:0];
                A_SMASK: st_d.smask = reg_wdata[NSR-1:0];
                A_RMASK: st_d.rmask = reg_wdata[NSR-1:0];
                A_TGEN:  st_d.tgen  = reg_wdata[NTG-1:0];
                default: ;
            endcase
            for (int j = 0; j < NCMP; j++) begin
                if (reg_addr == 4'(A_CMP0 + j)) st_d.cmp[j] = reg_wdata;
            end
        end
        st_d.flags = (st_q.flags & ~flag_clr) | flag_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[CTRL_RUN]          = st_q.run;
                reg_rdata[CTRL_EXT]          = st_q.ext;
                reg_rdata[CTRL_PSEL +: PSW]  = st_q.psel;
                for (int i = 0; i < NCAP; i++) begin
                    reg_rdata[CTRL_ESEL + 2*i +: 2] = st_q.esel[i];
                end
            end
            A_FLAGS: reg_rdata[NFLAG-1:0] = st_q.flags;
            A_COUNT: reg_rdata            = cnt;
            A_SMASK: reg_rdata[NSR-1:0]   = st_q.smask;
            A_RMASK: reg_rdata[NSR-1:0]   = st_q.rmask;
            A_TGEN:  reg_rdata[NTG-1:0]   = st_q.tgen;
            default: ;
        endcase
        for (int i = 0; i < NCAP; i++) begin
            if (reg_addr == 4'(A_CAP0 + i)) reg_rdata = cap_val[i];
        end
        for (int j = 0; j < NCMP; j++) begin
            if (reg_addr == 4'(A_CMP0 + j)) reg_rdata = st_q.cmp[j];
        end
    end

    assign evt_flags = st_q.flags;

    // R11
    ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> evt_flags[0]);

    // R12
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_FLAGS && reg_wdata[0] && !wrap) |=> !evt_flags[0]);
endmodule

// File: tb/tb_cct_timer_unit.sv
module tb_cct_timer_unit;
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [3:0] AD_CTRL = 4'd0, AD_FLAGS = 4'd1, AD_COUNT = 4'd2,
                           AD_CAP0 = 4'd3, AD_CMP0 = 4'd7, AD_SMASK = 4'd10,
                           AD_RMASK = 4'd11, AD_TGEN = 4'd12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cap_pin = '0;
    logic        evt_pin = 1'b0;
    logic        clr_pin = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [5:0]  sr_out;
    logic [1:0]  tg_out;
    logic [7:0]  evt_flags;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    cct_timer_unit dut (
        .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .evt_pin(evt_pin),
        .clr_pin(clr_pin), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sr_out(sr_out),
        .tg_out(tg_out), .evt_flags(evt_flags)
    );

    always #2 clk = ~clk;

    // reference model state
    logic [15:0] m_cnt;
    logic [2:0]  m_pre, m_lim;
    logic [15:0] m_cmp [3];
    logic [5:0]  m_sr, m_sm, m_rm;
    logic [1:0]  m_tg, m_te;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // called in the low phase of the clock; returns at the next falling edge
    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        reg_addr = a;
        #0.1;
        v = reg_rdata;
    endtask

    function automatic logic [2:0] div_lim(input int p);
        return 3'((1 << p) - 1);
    endfunction

    // one clock edge of a running, internally clocked counter
    task automatic model_step();
        logic tick, h0, h1, h2;
        tick = 1'b0;
        if (m_pre >= m_lim) begin m_pre = '0; tick = 1'b1; end
        else m_pre = m_pre + 1'b1;
        if (tick) begin
            m_cnt = m_cnt + 1'b1;
            h0 = (m_cnt == m_cmp[0]);
            h1 = (m_cnt == m_cmp[1]);
            h2 = (m_cnt == m_cmp[2]);
            if (h1) m_sr = m_sr & ~m_rm;
            if (h0) m_sr = m_sr | m_sm;
            if (h2) m_tg = m_tg ^ m_te;
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
        end
    end

    initial begin
        logic [15:0] v, w, c, f;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a <= 12; a++) begin
            rd(4'(a), v);
            chk("R1 register", v, 0);
        end
        chk("R1 sr_out", sr_out, 0);
        chk("R1 tg_out", tg_out, 0);
        chk("R1 flags", evt_flags, 0);

        // R2 R8 R9 R10: random rounds against the cycle model
        m_sr = '0; m_tg = '0;
        for (int r = 0; r < 8; r++) begin
            int p, span, rng;
            p    = (r == 0) ? 0 : int'($urandom % 4);
            span = 64;
            rng  = span >> p;
            rd(AD_COUNT, v);
            m_cnt = v;
            for (int j = 0; j < 3; j++) m_cmp[j] = m_cnt + 16'd1 + 16'($urandom % rng);
            m_sm = 6'($urandom); m_rm = 6'($urandom); m_te = 2'($urandom);
            if (r == 0) begin
                // R9: set and reset on the same value with overlapping masks
                m_cmp[1] = m_cmp[0];
                m_sm = 6'b101101; m_rm = 6'b111111;
            end
            for (int j = 0; j < 3; j++) wr(4'(AD_CMP0 + j), m_cmp[j]);
            wr(AD_SMASK, 16'(m_sm));
            wr(AD_RMASK, 16'(m_rm));
            wr(AD_TGEN, 16'(m_te));
            chk("R8 sr before run", sr_out, m_sr);
            chk("R10 tg before run", tg_out, m_tg);
            m_pre = '0; m_lim = div_lim(p);
            wr(AD_CTRL, 16'(1 | (p << 2)));
            for (int k = 1; k <= span; k++) begin
                @(posedge clk);
                model_step();
                @(negedge clk);
                rd(AD_COUNT, v);
                chk("R2 count", v, m_cnt);
                chk(r == 0 ? "R9 sr_out" : "R8 sr_out", sr_out, m_sr);
                chk("R10 tg_out", tg_out, m_tg);
            end
            wr(AD_CTRL, 16'h0000);
            model_step();
            rd(AD_COUNT, v);
            chk("R2 count at stop", v, m_cnt);
        end

        // R3: stopped counter ignores time and event pulses
        rd(AD_COUNT, c);
        for (int k = 0; k < 3; k++) begin
            evt_pin = 1'b1; repeat (3) @(negedge clk);
            evt_pin = 1'b0; repeat (3) @(negedge clk);
        end
        rd(AD_COUNT, v);
        chk("R3 hold", v, c);

        // R11: wrap from 0xFFFF
        wr(AD_FLAGS, 16'hFFFF);
        rd(AD_COUNT, c);
        wr(AD_CTRL, 16'h0001);
        repeat (32'h10000 - 32'(c) - 1) @(negedge clk);
        rd(AD_COUNT, v);
        chk("R11 count before wrap", v, 16'hFFFF);
        chk("R11 flag before wrap", evt_flags[0], 0);
        @(negedge clk);
        rd(AD_COUNT, v);
        chk("R11 count after wrap", v, 0);
        chk("R11 flag after wrap", evt_flags[0], 1);
        wr(AD_CTRL, 16'h0000);

        // R12: selective write-1-to-clear
        f = 16'(evt_flags);
        wr(AD_FLAGS, 16'h0001);
        rd(AD_FLAGS, v);
        chk("R12 clear bit 0 only", v, f & 16'h00FE);
        wr(AD_FLAGS, 16'h00FF);
        chk("R12 clear all", evt_flags, 0);

        // R5: clear pin
        wr(AD_CTRL, 16'h0001);
        clr_pin = 1'b1;
        repeat (3) @(negedge clk);
        rd(AD_COUNT, v);
        chk("R5 cleared", v, 0);
        @(negedge clk);
        rd(AD_COUNT, v);
        chk("R5 counts after clear", v, 1);
        repeat (5) @(negedge clk);
        rd(AD_COUNT, v);
        chk("R5 level does not clear", v, 6);
        clr_pin = 1'b0;

        // R6 R7: captures, ch0 rise, ch1 fall, ch2 both, ch3 off
        wr(AD_FLAGS, 16'h00FF);
        wr(AD_CTRL, 16'h3901);
        rd(AD_COUNT, v);
        cap_pin = 4'hF;
        repeat (3) @(negedge clk);
        rd(AD_CAP0 + 4'd0, c); chk("R6 rise ch0", c, v + 16'd2);
        rd(AD_CAP0 + 4'd2, c); chk("R6 both ch2 rising", c, v + 16'd2);
        rd(AD_CAP0 + 4'd1, c); chk("R6 fall ch1 ignores rise", c, 0);
        rd(AD_CAP0 + 4'd3, c); chk("R7 off ch3", c, 0);
        rd(AD_COUNT, w);
        cap_pin = 4'h0;
        repeat (3) @(negedge clk);
        rd(AD_CAP0 + 4'd1, c); chk("R6 fall ch1", c, w + 16'd2);
        rd(AD_CAP0 + 4'd2, c); chk("R6 both ch2 falling", c, w + 16'd2);
        rd(AD_CAP0 + 4'd0, c); chk("R6 rise ch0 ignores fall", c, v + 16'd2);
        rd(AD_CAP0 + 4'd3, c); chk("R7 off ch3 after fall", c, 0);
        chk("R7 capture flags", evt_flags[4:1], 4'b0111);

        // R4: external event counting
        wr(AD_CTRL, 16'h0000);
        rd(AD_COUNT, c);
        wr(AD_CTRL, 16'h000F);
        for (int k = 0; k < 5; k++) begin
            evt_pin = 1'b1; repeat (3) @(negedge clk);
            evt_pin = 1'b0; repeat (3) @(negedge clk);
        end
        repeat (3) @(negedge clk);
        rd(AD_COUNT, v);
        chk("R4 event count", v, c + 16'd5);
        evt_pin = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(AD_COUNT, v);
        chk("R4 edge latency not yet", v, c + 16'd5);
        @(negedge clk);
        rd(AD_COUNT, v);
        chk("R4 edge latency reached", v, c + 16'd6);
        evt_pin = 1'b0;
        wr(AD_CTRL, 16'h0000);

        done = 1'b1;
        summary();
    end
endmodule